// File: doc/BRIEF.md
# Compare Flags and Control-Flow Unit

This unit owns the two condition flags of a 32-bit processor and chooses the address of the next instruction. A compare operation loads the flags by testing one register value against a sign-extended 16-bit immediate. Both the equality and the less-than tests treat the operands as unsigned 32-bit numbers. Six conditional branches read the flags. A taken branch moves the program counter by the immediate counted in 4-byte instruction words, relative to the branch's own address. A register jump loads the program counter from a register. Jump-and-link does the same and also asks for the return address to be written into the link register. The system-call opcode and every undefined opcode each raise their own trap.

The block sits between the instruction decoder and the fetch stage. Each cycle it takes one decoded operation: its valid bit, opcode, the source register value, the raw immediate and the address of that operation. In the same cycle it returns the next program counter, the link-write request and the trap lines. The flags are registered and update on the clock edge that ends a compare.

Top module: `ctrl_flow_unit`

## Requirements
- R1: After reset both flags, `flag_z` and `flag_n`, read 0.
- R2: A valid compare (opcode 0x12) makes `flag_z` 1 from the next cycle if `reg_val` equals the immediate sign-extended to 32 bits, and 0 otherwise.
- R3: A valid compare makes `flag_n` 1 from the next cycle if `reg_val` is less than the sign-extended immediate, both taken as unsigned 32-bit values, and 0 otherwise.
- R4: The flags keep their value through every cycle that is not a valid compare, including a compare opcode presented with `op_valid` low.
- R5: The branch opcodes and their take conditions are: 0x13 takes when Z, 0x14 when not Z, 0x15 when N, 0x16 when not N, 0x17 when Z or N, and 0x18 when neither Z nor N.
- R6: A taken branch gives `pc_next = pc_cur + sext(imm) * 4`. A branch that is not taken gives `pc_cur + 4`. A branch never requests a link write or a trap.
- R7: A register jump (opcode 0x19) gives `pc_next = reg_val`, with no link write and no trap.
- R8: Jump-and-link (opcode 0x1A) gives `pc_next = reg_val`. It raises `link_we` with `link_data = pc_cur + 4`, and `link_idx` is register 31. It raises no trap.
- R9: The system-call opcode 0x1B raises `trap_sys` only, and `pc_next = pc_cur + 4`.
- R10: Opcodes 0x1C to 0x3F raise `trap_ill` only, and `pc_next = pc_cur + 4`.
- R11: Opcodes 0x00 to 0x12, which are the plain operations and compare, give `pc_next = pc_cur + 4` with no link write and no trap.
- R12: With `op_valid` low, `pc_next = pc_cur`, and no link write and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A decoded operation is present |
| opcode | input | 6 | Primary opcode of the operation |
| reg_val | input | 32 | Source register value (bits 25:21 of the instruction select it) |
| imm | input | 16 | Raw immediate field |
| pc_cur | input | 32 | Address of the current operation |
| pc_next | output | 32 | Address of the next operation |
| link_we | output | 1 | Request to write the return address |
| link_idx | output | 5 | Register index for the return address |
| link_data | output | 32 | Return address value |
| trap_sys | output | 1 | System-call trap |
| trap_ill | output | 1 | Illegal-instruction trap |
| flag_z | output | 1 | Zero / equal flag |
| flag_n | output | 1 | Unsigned less-than flag |

## Verification
Compare is swept over register values against immediates around the sign boundary of the 16-bit field, such as 0x7FFF, 0x8000 and 0xFFFF. This separates an unsigned test from a signed one, and a sign-extended immediate from a zero-extended one. Each of the three reachable flag states (equal, below, above) is paired with all six branch opcodes and with offsets 0, ±1 and the two extremes, which shows the word scaling and that the base is the branch's own address. All 64 opcodes are then applied with the valid bit high and then low, to check the trap split, the link request and the idle hold. A compare presented while not valid must leave the flags untouched.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OP_LAST_PLAIN = 6'h11;
    localparam logic [OPC_W-1:0] OP_CMP        = 6'h12;
    localparam logic [OPC_W-1:0] OP_BR_FIRST   = 6'h13;
    localparam logic [OPC_W-1:0] OP_BR_LAST    = 6'h18;
    localparam logic [OPC_W-1:0] OP_JREG       = 6'h19;
    localparam logic [OPC_W-1:0] OP_JLINK      = 6'h1A;
    localparam logic [OPC_W-1:0] OP_SYSCALL    = 6'h1B;

    localparam int NUM_COND = 6;

    typedef enum logic [2:0] {
        CLS_IDLE,
        CLS_PLAIN,
        CLS_CMP,
        CLS_BRANCH,
        CLS_JREG,
        CLS_JLINK,
        CLS_SYS,
        CLS_ILL
    } op_class_e;

    typedef enum logic [2:0] {
        BC_EQ,
        BC_NE,
        BC_LT,
        BC_GE,
        BC_LE,
        BC_GT,
        BC_RSV6,
        BC_RSV7
    } br_cond_e;

    typedef struct packed {
        op_class_e cls;
        br_cond_e  cond;
    } dec_t;

    typedef struct packed {
        logic z;
        logic n;
    } flags_t;

    function automatic logic cond_met(input br_cond_e c, input flags_t f);
        case (c)
            BC_EQ:   return f.z;
            BC_NE:   return !f.z;
            BC_LT:   return f.n;
            BC_GE:   return !f.n;
            BC_LE:   return f.z || f.n;
            BC_GT:   return !f.z && !f.n;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cfu_decode.sv
module cfu_decode
    import cfu_pkg::*;
(
    input  logic             op_valid,
    input  logic [OPC_W-1:0] opcode,
    output dec_t             dec
);

    always_comb begin
        dec.cls  = CLS_IDLE;
        dec.cond = BC_EQ;
        if (!op_valid) begin
            dec.cls = CLS_IDLE;
        end else if (opcode <= OP_LAST_PLAIN) begin
            dec.cls = CLS_PLAIN;
        end else if (opcode == OP_CMP) begin
            dec.cls = CLS_CMP;
        end else if (opcode >= OP_BR_FIRST && opcode <= OP_BR_LAST) begin
            dec.cls  = CLS_BRANCH;
            dec.cond = br_cond_e'(opcode[2:0] - OP_BR_FIRST[2:0]);
        end else if (opcode == OP_JREG) begin
            dec.cls = CLS_JREG;
        end else if (opcode == OP_JLINK) begin
            dec.cls = CLS_JLINK;
        end else if (opcode == OP_SYSCALL) begin
            dec.cls = CLS_SYS;
        end else begin
            dec.cls = CLS_ILL;
        end
    end

endmodule

// File: rtl/cfu_flags.sv
module cfu_flags
    import cfu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmp_en,
    input  logic [XLEN-1:0] reg_val,
    input  logic [XLEN-1:0] imm_ext,
    output flags_t          flags
);

    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (cmp_en) begin
            fl_d.z = (reg_val == imm_ext);
            fl_d.n = (reg_val < imm_ext);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags = fl_q;

    // R4
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> $stable(fl_q));

    // R3
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_q.z && fl_q.n));

endmodule

// File: rtl/cfu_next_pc.sv
module cfu_next_pc
    import cfu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  dec_t            dec,
    input  flags_t          flags,
    input  logic [XLEN-1:0] reg_val,
    input  logic [XLEN-1:0] imm_ext,
    input  logic [XLEN-1:0] pc_cur,
    output logic [XLEN-1:0] pc_next,
    output logic            link_we,
    output logic [XLEN-1:0] link_data,
    output logic            trap_sys,
    output logic            trap_ill
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [7:0]      cond_vec;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_pc;

    for (genvar g = 0; g < NUM_COND; g++) begin : g_cond
        assign cond_vec[g] = cond_met(br_cond_e'(3'(g)), flags);
    end
    assign cond_vec[7:NUM_COND] = '0;

    assign seq_pc = pc_cur + STEP;
    assign br_pc  = pc_cur + (imm_ext << 2);

    always_comb begin
        pc_next   = seq_pc;
        link_we   = 1'b0;
        link_data = seq_pc;
        trap_sys  = 1'b0;
        trap_ill  = 1'b0;
        case (dec.cls)
            CLS_IDLE:   pc_next = pc_cur;
            CLS_BRANCH: if (cond_vec[dec.cond]) pc_next = br_pc;
            CLS_JREG:   pc_next = reg_val;
            CLS_JLINK: begin
                pc_next = reg_val;
                link_we = 1'b1;
            end
            CLS_SYS:    trap_sys = 1'b1;
            CLS_ILL:    trap_ill = 1'b1;
            default:    pc_next = seq_pc;
        endcase
    end

endmodule

// File: rtl/ctrl_flow_unit.sv
module ctrl_flow_unit
    import cfu_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int IMM_W     = 16,
    parameter int REG_IDX_W = 5,
    parameter int LINK_REG  = 31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [OPC_W-1:0]     opcode,
    input  logic [XLEN-1:0]      reg_val,
    input  logic [IMM_W-1:0]     imm,
    input  logic [XLEN-1:0]      pc_cur,
    output logic [XLEN-1:0]      pc_next,
    output logic                 link_we,
    output logic [REG_IDX_W-1:0] link_idx,
    output logic [XLEN-1:0]      link_data,
    output logic                 trap_sys,
    output logic                 trap_ill,
    output logic                 flag_z,
    output logic                 flag_n
);

    localparam int EXT_W = XLEN - IMM_W;

    dec_t            dec;
    flags_t          flags;
    logic [XLEN-1:0] imm_ext;

    assign imm_ext  = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign link_idx = REG_IDX_W'(LINK_REG);

    cfu_decode i_decode (
        .op_valid (op_valid),
        .opcode   (opcode),
        .dec      (dec)
    );

    cfu_flags #(.XLEN(XLEN)) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_en  (dec.cls == CLS_CMP),
        .reg_val (reg_val),
        .imm_ext (imm_ext),
        .flags   (flags)
    );

    cfu_next_pc #(.XLEN(XLEN)) i_next_pc (
        .dec       (dec),
        .flags     (flags),
        .reg_val   (reg_val),
        .imm_ext   (imm_ext),
        .pc_cur    (pc_cur),
        .pc_next   (pc_next),
        .link_we   (link_we),
        .link_data (link_data),
        .trap_sys  (trap_sys),
        .trap_ill  (trap_ill)
    );

    assign flag_z = flags.z;
    assign flag_n = flags.n;

    // R8 R9 R10
    side_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_sys, trap_ill, link_we}));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> (pc_next == pc_cur && !link_we && !trap_sys && !trap_ill));

    // R8
    jlink_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (pc_next == reg_val && op_valid));

    // R10
    ill_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ill |-> (pc_next == pc_cur + XLEN'(4)));

endmodule

// File: tb/test_ctrl_flow_unit.sv
module test_ctrl_flow_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [5:0]  opcode = '0;
    logic [31:0] reg_val = '0;
    logic [15:0] imm = '0;
    logic [31:0] pc_cur = '0;
    logic [31:0] pc_next;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_data;
    logic        trap_sys;
    logic        trap_ill;
    logic        flag_z;
    logic        flag_n;

    int n_chk  = 0;
    int n_fail = 0;
    logic m_z = 1'b0;
    logic m_n = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ctrl_flow_unit i_ctrl_flow_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .opcode    (opcode),
        .reg_val   (reg_val),
        .imm       (imm),
        .pc_cur    (pc_cur),
        .pc_next   (pc_next),
        .link_we   (link_we),
        .link_idx  (link_idx),
        .link_data (link_data),
        .trap_sys  (trap_sys),
        .trap_ill  (trap_ill),
        .flag_z    (flag_z),
        .flag_n    (flag_n)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic v, input logic [5:0] op);
        if (!v)                        return "R12";
        if (op <= 6'h12)               return "R11";
        if (op >= 6'h13 && op <= 6'h18) return "R5 R6";
        if (op == 6'h19)               return "R7";
        if (op == 6'h1A)               return "R8";
        if (op == 6'h1B)               return "R9";
        return "R10";
    endfunction

    task automatic apply(input logic v, input logic [5:0] op, input logic [31:0] r,
                         input logic [15:0] im, input logic [31:0] pc);
        logic [31:0] ix;
        logic [31:0] e_pc;
        logic        e_lwe, e_ts, e_ti, tk;
        string       t;
        @(negedge clk);
        op_valid = v; opcode = op; reg_val = r; imm = im; pc_cur = pc;
        #1;
        ix = {{16{im[15]}}, im};
        t  = tag_of(v, op);
        e_pc = pc + 32'd4; e_lwe = 1'b0; e_ts = 1'b0; e_ti = 1'b0; tk = 1'b0;
        if (!v) begin
            e_pc = pc;
        end else if (op >= 6'h13 && op <= 6'h18) begin
            case (op)
                6'h13:   tk = m_z;
                6'h14:   tk = !m_z;
                6'h15:   tk = m_n;
                6'h16:   tk = !m_n;
                6'h17:   tk = m_z || m_n;
                default: tk = !m_z && !m_n;
            endcase
            if (tk) e_pc = pc + ix * 32'd4;
        end else if (op == 6'h19) begin
            e_pc = r;
        end else if (op == 6'h1A) begin
            e_pc = r; e_lwe = 1'b1;
        end else if (op == 6'h1B) begin
            e_ts = 1'b1;
        end else if (op > 6'h1B) begin
            e_ti = 1'b1;
        end
        chk(pc_next === e_pc, t, "pc_next", pc_next, e_pc);
        chk(link_we === e_lwe, t, "link_we", 32'(link_we), 32'(e_lwe));
        chk(trap_sys === e_ts, t, "trap_sys", 32'(trap_sys), 32'(e_ts));
        chk(trap_ill === e_ti, t, "trap_ill", 32'(trap_ill), 32'(e_ti));
        if (e_lwe) begin
            chk(link_data === pc + 32'd4, "R8", "link_data", link_data, pc + 32'd4);
            chk(link_idx === 5'd31, "R8", "link_idx", 32'(link_idx), 32'd31);
        end
        // R2 R3 R4: flags reflect the last valid compare only
        chk(flag_z === m_z, "R2 R4", "flag_z", 32'(flag_z), 32'(m_z));
        chk(flag_n === m_n, "R3 R4", "flag_n", 32'(flag_n), 32'(m_n));
        @(posedge clk);
        if (v && op == 6'h12) begin
            m_z = (r == ix);
            m_n = (r < ix);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] regs [8];
        logic [15:0] imms [5];
        logic [15:0] offs [5];
        logic [31:0] pcs  [2];
        regs = '{32'h0, 32'h1, 32'h7FFF, 32'h8000, 32'hFFFF7FFF,
                 32'hFFFF8000, 32'hFFFFFFFE, 32'hFFFFFFFF};
        imms = '{16'h0, 16'h1, 16'h7FFF, 16'h8000, 16'hFFFF};
        offs = '{16'h0, 16'h1, 16'hFFFF, 16'h7FFF, 16'h8000};
        pcs  = '{32'h0000_1000, 32'h0000_0000};

        repeat (2) @(posedge clk);
        #1;
        // R1: flags clear while and after reset
        chk(flag_z === 1'b0, "R1", "flag_z", 32'(flag_z), 32'd0);
        chk(flag_n === 1'b0, "R1", "flag_n", 32'(flag_n), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(flag_z === 1'b0 && flag_n === 1'b0, "R1", "flags", {30'd0, flag_z, flag_n}, 32'd0);

        // R2 R3: compare sweep across the sign boundary of the immediate
        foreach (regs[i]) begin
            foreach (imms[j]) begin
                apply(1'b1, 6'h12, regs[i], imms[j], 32'h100);
                // R4: invalid compare with different operands must not touch flags
                apply(1'b0, 6'h12, ~regs[i], imms[j] ^ 16'h1, 32'h104);
            end
        end

        // R5 R6: every flag state against every branch and offset
        for (int s = 0; s < 3; s++) begin
            apply(1'b1, 6'h12, 32'd3 + 32'(s * 2), 16'd5, 32'h200);
            for (int b = 6'h13; b <= 6'h18; b++) begin
                foreach (offs[k]) begin
                    foreach (pcs[p]) begin
                        apply(1'b1, 6'(b), 32'hDEAD_BEE0, offs[k], pcs[p]);
                    end
                end
            end
        end

        // R7 to R12: every opcode with the valid bit high and low
        for (int op = 0; op < 64; op++) begin
            if (op == 6'h12) continue;
            apply(1'b1, 6'(op), 32'h0040_0010, 16'h0003, 32'h0000_3000);
            apply(1'b0, 6'(op), 32'h0040_0010, 16'h0003, 32'h0000_3004);
            apply(1'b1, 6'(op), 32'hFFFF_FFFC, 16'h8000, 32'hFFFF_FFFC);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule